// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Controller

This block collects eight interrupt sources into sticky status bits, filters them through a mask register, and raises an active-low request toward the processor. It sits in a priority daisy chain. A device earlier in the chain grants permission through the chain-enable input. This device passes that permission on through the chain-enable output only while it has nothing pending and nothing in service.

During an acknowledge, the device that holds permission and is requesting places its programmable 8-bit vector on the data output and asserts the output enable. The acknowledged bits then stay in service and keep blocking the chain until software clears them. A small register port gives access to the state:

| Address | Register | Access |
|---|---|---|
| 0 | raw status | read, write-one-to-clear |
| 1 | mask | read/write |
| 2 | masked status | read only |
| 3 | vector | read/write |

Top module: `vec_irq_chain`

## Requirements
- R1: A high bit on `src_i` at a clock edge sets the matching status bit. The bit stays set, and it reads back at address 0 from the next cycle on.
- R2: Writing to address 0 clears every status bit whose `reg_wdata` bit is 1. If a source pulse arrives in the same cycle as the clear, the bit stays set.
- R3: The mask at address 1 is read/write. Address 2 reads the bitwise AND of status and mask, and writes to address 2 have no effect.
- R4: `intr_n` is low exactly when `chain_en_i` is high and at least one masked status bit is set.
- R5: `chain_en_o` is high exactly when `chain_en_i` is high, no masked status bit is set, and no bit is in service.
- R6: `vec_oe` is high, and `vec_o` equals the vector register, exactly when `ack_n` is low, `chain_en_i` is high and a masked status bit is set. Otherwise `vec_o` is 8'h00.
- R7: Each clock edge with `vec_oe` high puts the masked bits pending at that edge into service. A bit leaves service only when a write to address 0 clears it, and changing the mask does not release it.
- R8: The vector register at address 3 is read/write.
- R9: Reset clears status, mask and the in-service bits, and loads the vector with 8'h0F. After reset `intr_n` is high and `chain_en_o` follows `chain_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Interrupt source pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| chain_en_i | input | 1 | Daisy-chain enable from higher priority |
| chain_en_o | output | 1 | Daisy-chain enable to lower priority |
| ack_n | input | 1 | Interrupt acknowledge, active low |
| intr_n | output | 1 | Interrupt request, active low |
| vec_o | output | 8 | Vector data output |
| vec_oe | output | 1 | Vector output enable |

## Verification
Source pulses, register writes and acknowledges all act at the next rising edge. Their effects on status, mask, vector and in-service state therefore appear one cycle later, on `reg_rdata`, `intr_n`, `chain_en_o` and `vec_oe`. Changes on `chain_en_i` and `ack_n` reach the outputs within the same cycle, because those paths are combinational.

The bench drives inputs just after the falling edge and compares every output a moment later. It updates its reference state only at the following rising edge, so each check sees exactly the state the design should hold in that cycle.

// File: rtl/vec_irq_chain.sv
module vec_irq_chain #(
  parameter int           NSRC      = 8,
  parameter logic [7:0]   VEC_RESET = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            chain_en_i,
  output logic            chain_en_o,
  input  logic            ack_n,
  output logic            intr_n,
  output logic [7:0]      vec_o,
  output logic            vec_oe
);

  localparam logic [1:0] A_STAT = 2'd0, A_MASK = 2'd1, A_MSTAT = 2'd2, A_VEC = 2'd3;

  logic [NSRC-1:0] status, mask, in_svc, pend, clr;
  logic [7:0]      vector;
  logic            req;

  assign pend = status & mask;
  assign req  = |pend;
  assign clr  = (reg_we && reg_addr == A_STAT) ? reg_wdata[NSRC-1:0] : '0;

  assign intr_n     = ~(chain_en_i & req);
  assign chain_en_o = chain_en_i & ~req & ~(|in_svc);
  assign vec_oe     = ~ack_n & chain_en_i & req;
  assign vec_o      = vec_oe ? vector : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
      in_svc <= '0;
      vector <= VEC_RESET;
    end else begin
      status <= (status & ~clr) | src_i;
      in_svc <= (in_svc & ~clr) | (vec_oe ? pend : '0);
      if (reg_we && reg_addr == A_MASK) mask   <= reg_wdata[NSRC-1:0];
      if (reg_we && reg_addr == A_VEC)  vector <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_STAT:  reg_rdata[NSRC-1:0] = status;
      A_MASK:  reg_rdata[NSRC-1:0] = mask;
      A_MSTAT: reg_rdata[NSRC-1:0] = pend;
      default: reg_rdata = vector;
    endcase
  end

  AST_SRC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_i) |=> ((status & $past(src_i)) == $past(src_i))); // R1
  AST_REQ_NEEDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !intr_n |-> chain_en_i); // R4
  AST_CHAIN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chain_en_o |-> (intr_n && !vec_oe)); // R5
  AST_VEC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (!ack_n && !intr_n)); // R6
  AST_SVC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && !(reg_we && reg_addr == A_STAT)) |=> !chain_en_o); // R7

endmodule

// File: tb/vec_irq_chain_tb.sv
module vec_irq_chain_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] src_i = '0, reg_wdata = '0;
  logic reg_we = 1'b0, chain_en_i = 1'b0, ack_n = 1'b1;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_rdata, vec_o;
  logic chain_en_o, intr_n, vec_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_st, m_mk, m_vec, m_svc;

  always #2 clk = ~clk;

  vec_irq_chain dut_i (.clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chain_en_i(chain_en_i), .chain_en_o(chain_en_o), .ack_n(ack_n),
    .intr_n(intr_n), .vec_o(vec_o), .vec_oe(vec_oe));

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_st;
      2'd1: return m_mk;
      2'd2: return m_st & m_mk;
      default: return m_vec;
    endcase
  endfunction

  function automatic logic exp_oe();
    return !ack_n && chain_en_i && |(m_st & m_mk);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [7:0] s, logic we, logic [1:0] a, logic [7:0] wd, logic ei, logic ak);
    logic [7:0] clr;
    logic oe;
    @(negedge clk);
    src_i = s; reg_we = we; reg_addr = a; reg_wdata = wd; chain_en_i = ei; ack_n = ak;
    #1;
    chk("R1/R3/R8 rdata", reg_rdata, exp_rd(a));
    chk("R4 intr_n", {7'd0, intr_n}, {7'd0, !(ei && |(m_st & m_mk))});
    chk("R5 chain_en_o", {7'd0, chain_en_o}, {7'd0, ei && !(|(m_st & m_mk)) && !(|m_svc)});
    oe = exp_oe();
    chk("R6 vec_oe", {7'd0, vec_oe}, {7'd0, oe});
    chk("R6 vec_o", vec_o, oe ? m_vec : 8'h00);
    @(posedge clk);
    clr = (we && a == 2'd0) ? wd : 8'h00;
    m_svc = (m_svc & ~clr) | (oe ? (m_st & m_mk) : 8'h00);
    m_st = (m_st & ~clr) | s;
    if (we && a == 2'd1) m_mk = wd;
    if (we && a == 2'd3) m_vec = wd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    m_st = 0; m_mk = 0; m_vec = 8'h0F; m_svc = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    for (int a = 0; a < 4; a++) cyc(8'h00, 0, a[1:0], 8'h00, 1, 1);
    chk("R9 vector reset", m_vec, 8'h0F);
    // R3 masked read with no mask, then enable
    cyc(8'h05, 0, 2'd0, 0, 1, 1);
    cyc(8'h00, 0, 2'd2, 0, 1, 1);
    cyc(8'h00, 1, 2'd1, 8'h04, 1, 1);
    cyc(8'h00, 1, 2'd2, 8'hFF, 1, 1);   // R3 write to masked status ignored
    cyc(8'h00, 0, 2'd2, 0, 1, 1);
    cyc(8'h00, 0, 2'd0, 0, 0, 0);       // R6 no drive without chain enable
    // R7 acknowledge, then drop the mask: chain stays blocked
    cyc(8'h00, 1, 2'd3, 8'hA5, 1, 1);   // R8
    cyc(8'h00, 0, 2'd3, 0, 1, 0);
    cyc(8'h00, 1, 2'd1, 8'h00, 1, 1);
    cyc(8'h00, 0, 2'd0, 0, 1, 1);
    chk("R7 blocked after mask drop", {7'd0, chain_en_o}, 8'h00);
    // R2 clear with simultaneous set on bit 2, then real clear
    cyc(8'h04, 1, 2'd0, 8'h04, 1, 1);
    cyc(8'h00, 0, 2'd0, 0, 1, 1);
    cyc(8'h00, 1, 2'd0, 8'hFF, 1, 1);
    cyc(8'h00, 0, 2'd0, 0, 1, 1);
    chk("R7 released after clear", {7'd0, chain_en_o}, 8'h01);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] s;
      logic we;
      s  = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
      we = ($urandom % 3 == 0);
      cyc(s, we, 2'($urandom), 8'($urandom), ($urandom % 5 != 0), ($urandom % 4 != 0));
    end
    finish_run();
  end
endmodule